// File: doc/BRIEF.md
# Lock-Stage Loop-Filter Parameter Selector

This block chooses which bandwidth code and damping code a digital PLL loop filter uses. Three parameter pairs are supplied as static inputs, one for each locking stage: starting, acquisition and locked. The block tracks the current stage and presents the matching pair to the filter. The filter itself is outside this block.

When the loop closes on a newly selected input, a starting window opens. The window lasts a fixed number of one-millisecond ticks, 2000 by default, which gives two seconds. When the window ends, the acquisition pair applies until the lock flag rises. After that, the locked pair applies. If lock is lost, the stage drops back to acquisition without a new starting window. Clearing the automatic-selection enable forces the locked pair onto the outputs in every stage, while the stage tracking carries on underneath.

Top module: `lpf_stage_sel`

## Requirements
- R1: While reset is asserted, and directly after it, the stage output reads 0 (starting) and the outputs carry the starting pair when automatic selection is enabled.
- R2: The stage output encodes starting as 0, acquisition as 1 and locked as 2. The value 3 never appears.
- R3: With the loop closed, the stage leaves starting only on the clock edge that samples the START_TICKS-th tick of the window. From that edge it reads 1. Cycles without a tick do not advance the window.
- R4: A low loop-closed flag returns the stage to 0 on the next edge, from any stage, and clears the window count. When the loop closes again, a full START_TICKS ticks are needed.
- R5: In acquisition with the loop closed, a high lock flag moves the stage to 2 on the next edge.
- R6: In the locked stage with the loop closed, a low lock flag moves the stage to 1 on the next edge. The stage then stays in 1, without restarting the window, until lock returns.
- R7: The lock flag has no effect during the starting window. The window always runs to completion and passes through acquisition before reaching the locked stage.
- R8: With automatic selection enabled, the bandwidth and damping outputs equal the pair of the current stage (start_*, acq_* or lock_*). They follow the stage without delay.
- R9: With automatic selection disabled, the outputs equal lock_bw and lock_damp whatever the stage, and stage tracking continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse each millisecond |
| loop_closed | input | 1 | High while the loop is closed on a selected input |
| lock_ok | input | 1 | High while the loop reports lock |
| auto_sel | input | 1 | 1: pair follows stage; 0: locked pair always |
| start_bw | input | BW_W | Starting-stage bandwidth code |
| start_damp | input | DAMP_W | Starting-stage damping code |
| acq_bw | input | BW_W | Acquisition-stage bandwidth code |
| acq_damp | input | DAMP_W | Acquisition-stage damping code |
| lock_bw | input | BW_W | Locked-stage bandwidth code |
| lock_damp | input | DAMP_W | Locked-stage damping code |
| bw_code | output | BW_W | Active bandwidth code |
| damp_code | output | DAMP_W | Active damping code |
| stage | output | 2 | Current stage, 0/1/2 |

## Verification
The bench targets the edge of the starting window. It checks the cycle just before the last tick and the cycle just after it. A count that is off by one, or that counts clock cycles instead of ticks, would show the wrong stage at one of those samples. It holds the lock flag high through a whole window, so a design that took a shortcut to the locked stage would be caught. It also opens the loop partway through a window, which catches a design that resumes a stale count. Finally, it drops lock after locking and watches for a spurious return to starting, and it toggles automatic selection to confirm that only the outputs change and the stage does not.

// File: rtl/lpf_stage_sel.sv
module lpf_stage_sel #(
  parameter int BW_W        = 5,
  parameter int DAMP_W      = 3,
  parameter int START_TICKS = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              loop_closed,
  input  logic              lock_ok,
  input  logic              auto_sel,
  input  logic [BW_W-1:0]   start_bw,
  input  logic [DAMP_W-1:0] start_damp,
  input  logic [BW_W-1:0]   acq_bw,
  input  logic [DAMP_W-1:0] acq_damp,
  input  logic [BW_W-1:0]   lock_bw,
  input  logic [DAMP_W-1:0] lock_damp,
  output logic [BW_W-1:0]   bw_code,
  output logic [DAMP_W-1:0] damp_code,
  output logic [1:0]        stage
);

  localparam int CNT_W = $clog2(START_TICKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(START_TICKS - 1);
  localparam logic [1:0] ST_START = 2'd0;
  localparam logic [1:0] ST_ACQ   = 2'd1;
  localparam logic [1:0] ST_LOCK  = 2'd2;

  logic [CNT_W-1:0] win_cnt;
  logic             use_lock, use_acq;

  always_ff @(posedge clk) begin
    if (!rst_n || !loop_closed) begin
      stage   <= ST_START;
      win_cnt <= '0;
    end else begin
      case (stage)
        ST_START:
          if (tick_ms) begin
            if (win_cnt == LAST) begin
              stage   <= ST_ACQ;
              win_cnt <= '0;
            end else begin
              win_cnt <= win_cnt + 1'b1;
            end
          end
        ST_ACQ:  if (lock_ok)  stage <= ST_LOCK;
        ST_LOCK: if (!lock_ok) stage <= ST_ACQ;
        default: stage <= ST_START;
      endcase
    end
  end

  assign use_lock  = !auto_sel || (stage == ST_LOCK);
  assign use_acq   = stage == ST_ACQ;
  assign bw_code   = use_lock ? lock_bw   : use_acq ? acq_bw   : start_bw;
  assign damp_code = use_lock ? lock_damp : use_acq ? acq_damp : start_damp;

  p_stage_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stage != 2'd3);

  p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    win_cnt < CNT_W'(START_TICKS));

  p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_START && loop_closed && !tick_ms) |=> stage == ST_START);

  p_open_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_closed |=> (stage == ST_START && win_cnt == '0));

  p_enter_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_ACQ && loop_closed && lock_ok) |=> stage == ST_LOCK);

  p_lose_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == ST_LOCK && loop_closed && !lock_ok) |=> stage == ST_ACQ);

  p_no_shortcut_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stage == ST_START |=> stage != ST_LOCK);

  p_forced_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_sel |-> (bw_code == lock_bw && damp_code == lock_damp));

endmodule

// File: tb/lpf_stage_sel_tb.sv
module lpf_stage_sel_tb;
  localparam int N = 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0, loop_closed = 1'b0, lock_ok = 1'b0, auto_sel = 1'b1;
  logic [4:0] start_bw = 5'd3,  acq_bw = 5'd10, lock_bw = 5'd21;
  logic [2:0] start_damp = 3'd1, acq_damp = 3'd3, lock_damp = 3'd6;
  logic [4:0] bw_code;
  logic [2:0] damp_code;
  logic [1:0] stage;

  always #2 clk = ~clk;

  lpf_stage_sel u_dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .loop_closed(loop_closed),
    .lock_ok(lock_ok), .auto_sel(auto_sel),
    .start_bw(start_bw), .start_damp(start_damp),
    .acq_bw(acq_bw), .acq_damp(acq_damp),
    .lock_bw(lock_bw), .lock_damp(lock_damp),
    .bw_code(bw_code), .damp_code(damp_code), .stage(stage));

  typedef struct {
    logic [1:0] st;
    logic [4:0] bw;
    logic [2:0] dp;
    string      req;
  } exp_t;

  exp_t sb[$];
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic exp_t mk(logic [1:0] st, logic au, string req);
    exp_t e;
    e.st = st; e.req = req;
    if (!au || st == 2'd2) begin e.bw = 5'd21; e.dp = 3'd6; end
    else if (st == 2'd1)   begin e.bw = 5'd10; e.dp = 3'd3; end
    else                   begin e.bw = 5'd3;  e.dp = 3'd1; end
    return e;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (stage !== e.st || bw_code !== e.bw || damp_code !== e.dp) begin
      errors++;
      $display("FAIL %s: stage/bw/damp got %0d/%0d/%0d expected %0d/%0d/%0d",
               e.req, stage, bw_code, damp_code, e.st, e.bw, e.dp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) compare(sb.pop_front());
  end

  task automatic cyc(logic tk, logic cl, logic lk, logic au,
                     bit chk, logic [1:0] st, string req);
    @(negedge clk);
    tick_ms = tk; loop_closed = cl; lock_ok = lk; auto_sel = au;
    if (chk) sb.push_back(mk(st, au, req));
  endtask

  // Full window: ticks every third cycle; checks just before and after the last tick.
  task automatic window(logic lk, logic au, string req);
    for (int k = 1; k <= N; k++) begin
      cyc(0, 1, lk, au, k == N, 2'd0, req);
      cyc(0, 1, lk, au, 0, 2'd0, req);
      cyc(1, 1, lk, au, k == N, 2'd1, req);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare(mk(2'd0, 1'b1, "R1"));
    rst_n = 1'b1;
    cyc(0, 1, 0, 1, 1, 2'd0, "R1");
    window(0, 1, "R3");
    cyc(0, 1, 0, 1, 1, 2'd1, "R8");
    cyc(0, 1, 1, 1, 1, 2'd2, "R5");
    cyc(0, 1, 0, 1, 1, 2'd1, "R6");
    for (int i = 0; i < 6; i++) cyc(i % 2, 1, 0, 1, i == 5, 2'd1, "R6");
    cyc(0, 1, 0, 0, 1, 2'd1, "R9");
    cyc(0, 0, 0, 1, 1, 2'd0, "R4");
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0, 0, 2'd0, "R4");
    cyc(0, 0, 1, 0, 1, 2'd0, "R4");
    window(1, 0, "R7");
    cyc(0, 1, 1, 0, 1, 2'd2, "R5");
    cyc(0, 1, 1, 1, 1, 2'd2, "R8");
    cyc(0, 0, 1, 1, 1, 2'd0, "R4");
    cyc(0, 0, 0, 1, 0, 2'd0, "R4");
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule